// File: doc/BRIEF.md
# Double Data Rate Pad Buffer

This block sits between core logic and a group of pad signals and moves two data bits per pad per clock period. On the receive side it samples every pad on both clock edges and gives the core two lanes, both updated on the rising edge. On the transmit side it takes two lanes on the rising edge and drives them onto the pad one after the other: the first while the clock is high, the second while it is low.

A parameter selects receive-only, transmit-only or two-way operation. A per-bit polarity mask covers pads that are wired inverted, and a second option drives a complementary leg for differential pairs. Pads are modelled as separate input, output and enable vectors, so no tristate cell is needed.

Top module: `ddr_io_buffer`

## Requirements
- R1: With DIR 0 (receive) or 2 (two-way), the pad value present at rising edge k, XORed with INV_MASK, appears on rx_lane0 after rising edge k+1.
- R2: With DIR 0 or 2, the pad value present at the falling edge between rising edges k and k+1, XORed with INV_MASK, appears on rx_lane1 after rising edge k+1.
- R3: rx_lane0 and rx_lane1 change only at rising edges. They hold their values through the low phase even when pad_in changes.
- R4: With DIR 1 (transmit) or 2, tx_lane0 and tx_lane1 are sampled at rising edge k. During the high phase after edge k, pad_out equals tx_lane0 XOR INV_MASK. During the low phase that follows, it equals tx_lane1 XOR INV_MASK.
- R5: tx_en is sampled at rising edge k and drives pad_oe, unchanged, through both phases of that period.
- R6: While rst is high at a rising edge, every lane register clears to zero, so pad_out shows INV_MASK. pad_oe resets to 1 with DIR 1 and to 0 with DIR 2.
- R7: With DIFF 1, pad_out_n is the bitwise complement of pad_out in both phases. With DIFF 0, pad_out_n is held at zero.
- R8: With DIR 0, pad_out and pad_oe are held at zero and the tx inputs have no effect. With DIR 1, both rx lanes are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is the active edge |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | WIDTH | Value read back from the pads |
| pad_out | output | WIDTH | Value driven to the pads (positive leg) |
| pad_out_n | output | WIDTH | Complementary leg for differential pads |
| pad_oe | output | 1 | Pad output enable |
| rx_lane0 | output | WIDTH | Receive lane taken at the rising edge |
| rx_lane1 | output | WIDTH | Receive lane taken at the falling edge |
| tx_lane0 | input | WIDTH | Transmit lane driven in the high phase |
| tx_lane1 | input | WIDTH | Transmit lane driven in the low phase |
| tx_en | input | 1 | Requested output enable |

## Verification
The falling-edge pad check assumes that tx_lane0 changes only while the clock is high. Under that assumption, the value seen at the previous falling edge is the one the following rising edge captured. The stimulus meets this: it changes the transmit inputs 1 ns after each rising edge and pad_in 1 ns after each edge, so no input moves at an edge. The receive assertions assume that reset is released during a low phase. That way the first falling-edge capture after reset still sees reset.

// File: rtl/ddr_io_pkg.sv
package ddr_io_pkg;

    typedef enum logic [1:0] {
        DDR_RECV  = 2'd0,
        DDR_XMIT  = 2'd1,
        DDR_TWOWY = 2'd2
    } ddr_dir_e;

    function automatic bit dir_has_rx(input int dir);
        return dir != int'(DDR_XMIT);
    endfunction

    function automatic bit dir_has_tx(input int dir);
        return dir != int'(DDR_RECV);
    endfunction

    function automatic logic oe_reset_value(input int dir);
        return (dir == int'(DDR_XMIT)) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/ddr_rx_capture.sv
module ddr_rx_capture #(
    parameter int             WIDTH    = 8,
    parameter logic [WIDTH-1:0] INV_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] lane0,
    output logic [WIDTH-1:0] lane1
);
    logic [WIDTH-1:0] pad_fixed;
    logic [WIDTH-1:0] rise_cap;
    logic [WIDTH-1:0] fall_cap;

    assign pad_fixed = pad_in ^ INV_MASK;

    // first stage on the rising edge
    always_ff @(posedge clk) begin
        if (rst) rise_cap <= '0;
        else     rise_cap <= pad_fixed;
    end

    // first stage on the falling edge
    always_ff @(negedge clk) begin
        if (rst) fall_cap <= '0;
        else     fall_cap <= pad_fixed;
    end

    // realign both lanes onto the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            lane0 <= '0;
            lane1 <= '0;
        end else begin
            lane0 <= rise_cap;
            lane1 <= fall_cap;
        end
    end
endmodule

// File: rtl/ddr_tx_launch.sv
module ddr_tx_launch #(
    parameter int   WIDTH   = 8,
    parameter logic OE_INIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lane0,
    input  logic [WIDTH-1:0] lane1,
    input  logic             en,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q,
    output logic             oe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
            oe_q <= OE_INIT;
        end else begin
            hi_q <= lane0;
            lo_q <= lane1;
            oe_q <= en;
        end
    end
endmodule

// File: rtl/ddr_pad_drive.sv
module ddr_pad_drive #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] INV_MASK = '0,
    parameter bit               DIFF     = 1'b0
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] hi_q,
    input  logic [WIDTH-1:0] lo_q,
    input  logic             oe_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_out_n,
    output logic             pad_oe
);
    logic [WIDTH-1:0] phase_data;

    // high phase shows lane 0, low phase shows lane 1
    always_comb begin
        phase_data = clk ? hi_q : lo_q;
    end

    assign pad_out = phase_data ^ INV_MASK;
    assign pad_oe  = oe_q;

    generate
        if (DIFF) begin : g_diff
            assign pad_out_n = ~pad_out;
        end else begin : g_single
            assign pad_out_n = '0;
        end
    endgenerate
endmodule

// File: rtl/ddr_io_buffer.sv
module ddr_io_buffer
    import ddr_io_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter int               DIR      = 2,
    parameter logic [WIDTH-1:0] INV_MASK = '0,
    parameter bit               DIFF     = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_out_n,
    output logic             pad_oe,
    output logic [WIDTH-1:0] rx_lane0,
    output logic [WIDTH-1:0] rx_lane1,
    input  logic [WIDTH-1:0] tx_lane0,
    input  logic [WIDTH-1:0] tx_lane1,
    input  logic             tx_en
);
    localparam bit   HAS_RX  = dir_has_rx(DIR);
    localparam bit   HAS_TX  = dir_has_tx(DIR);
    localparam logic OE_INIT = oe_reset_value(DIR);

    generate
        if (HAS_RX) begin : g_rx
            ddr_rx_capture #(.WIDTH(WIDTH), .INV_MASK(INV_MASK)) u_rx (
                .clk(clk), .rst(rst), .pad_in(pad_in),
                .lane0(rx_lane0), .lane1(rx_lane1)
            );
        end else begin : g_no_rx
            logic unused_pad;
            assign unused_pad = ^pad_in;
            assign rx_lane0 = '0;
            assign rx_lane1 = '0;
        end

        if (HAS_TX) begin : g_tx
            logic [WIDTH-1:0] hi_q;
            logic [WIDTH-1:0] lo_q;
            logic             oe_q;
            ddr_tx_launch #(.WIDTH(WIDTH), .OE_INIT(OE_INIT)) u_launch (
                .clk(clk), .rst(rst), .lane0(tx_lane0), .lane1(tx_lane1),
                .en(tx_en), .hi_q(hi_q), .lo_q(lo_q), .oe_q(oe_q)
            );
            ddr_pad_drive #(.WIDTH(WIDTH), .INV_MASK(INV_MASK), .DIFF(DIFF)) u_drive (
                .clk(clk), .hi_q(hi_q), .lo_q(lo_q), .oe_q(oe_q),
                .pad_out(pad_out), .pad_out_n(pad_out_n), .pad_oe(pad_oe)
            );
        end else begin : g_no_tx
            logic unused_tx;
            assign unused_tx = ^{tx_lane0, tx_lane1, tx_en};
            assign pad_out   = '0;
            assign pad_out_n = '0;
            assign pad_oe    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ddr_io_buffer_chk.sv
module ddr_io_buffer_chk #(
    parameter int               WIDTH    = 8,
    parameter int               DIR      = 2,
    parameter logic [WIDTH-1:0] INV_MASK = '0,
    parameter bit               DIFF     = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_out_n,
    input logic             pad_oe,
    input logic [WIDTH-1:0] rx_lane0,
    input logic [WIDTH-1:0] rx_lane1,
    input logic [WIDTH-1:0] tx_lane0,
    input logic [WIDTH-1:0] tx_lane1,
    input logic             tx_en
);
    generate
        if (DIR != 1) begin : g_rx_chk
            // R1
            rise_lane_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(rst, 2)) |-> rx_lane0 == ($past(pad_in, 2) ^ INV_MASK));
        end else begin : g_norx_chk
            // R8
            rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
                rx_lane0 == '0 && rx_lane1 == '0);
        end

        if (DIR != 0) begin : g_tx_chk
            // R4
            low_phase_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> pad_out == ($past(tx_lane1) ^ INV_MASK));
            // R4
            high_phase_chk: assert property (@(negedge clk) disable iff (rst)
                !$past(rst) |-> pad_out == ($past(tx_lane0) ^ INV_MASK));
            // R5
            oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> pad_oe == $past(tx_en));
            // R6
            oe_reset_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> pad_oe == (DIR == 1));
        end else begin : g_notx_chk
            // R8
            tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
                pad_out == '0 && !pad_oe);
        end

        if (DIFF) begin : g_diff_chk
            // R7
            diff_leg_chk: assert property (@(negedge clk) disable iff (rst)
                pad_out_n == ~pad_out);
        end else begin : g_single_chk
            // R7
            single_leg_chk: assert property (@(posedge clk) disable iff (rst)
                pad_out_n == '0);
        end
    endgenerate
endmodule

bind ddr_io_buffer ddr_io_buffer_chk #(
    .WIDTH(WIDTH), .DIR(DIR), .INV_MASK(INV_MASK), .DIFF(DIFF)
) u_chk (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(pad_out),
    .pad_out_n(pad_out_n), .pad_oe(pad_oe), .rx_lane0(rx_lane0),
    .rx_lane1(rx_lane1), .tx_lane0(tx_lane0), .tx_lane1(tx_lane1),
    .tx_en(tx_en)
);

// File: tb/ddr_io_buffer_test.sv
module ddr_io_buffer_test;
    localparam int       W      = 8;
    localparam logic [W-1:0] MASK_B = 8'hA5;
    localparam logic [W-1:0] MASK_I = 8'h0F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0] pad_in = '0;
    logic [W-1:0] tx0 = '0;
    logic [W-1:0] tx1 = '0;
    logic         tx_en = 1'b0;

    logic [W-1:0] b_po, b_pn, b_r0, b_r1;
    logic         b_oe;
    logic [W-1:0] i_po, i_pn, i_r0, i_r1;
    logic         i_oe;
    logic [W-1:0] o_po, o_pn, o_r0, o_r1;
    logic         o_oe;

    ddr_io_buffer #(.WIDTH(W), .DIR(2), .INV_MASK(MASK_B), .DIFF(1'b1)) uut (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(b_po), .pad_out_n(b_pn),
        .pad_oe(b_oe), .rx_lane0(b_r0), .rx_lane1(b_r1),
        .tx_lane0(tx0), .tx_lane1(tx1), .tx_en(tx_en));

    ddr_io_buffer #(.WIDTH(W), .DIR(0), .INV_MASK(MASK_I), .DIFF(1'b0)) uut_rx (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(i_po), .pad_out_n(i_pn),
        .pad_oe(i_oe), .rx_lane0(i_r0), .rx_lane1(i_r1),
        .tx_lane0(tx0), .tx_lane1(tx1), .tx_en(tx_en));

    ddr_io_buffer #(.WIDTH(W), .DIR(1), .INV_MASK('0), .DIFF(1'b0)) uut_tx (
        .clk(clk), .rst(rst), .pad_in(pad_in), .pad_out(o_po), .pad_out_n(o_pn),
        .pad_oe(o_oe), .rx_lane0(o_r0), .rx_lane1(o_r1),
        .tx_lane0(tx0), .tx_lane1(tx1), .tx_en(tx_en));

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [W-1:0] pattern(input int n);
        if (n < 32)      return W'(1) << (n % W);
        else if (n < 64) return (n % 2) ? '1 : '0;
        else             return W'($urandom);
    endfunction

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // reference state: expected lane contents per receive instance
    logic [W-1:0] rise_b = '0, fall_b = '0, rise_i = '0, fall_i = '0;
    logic [W-1:0] s0, s1, h0, h1, e0b, e1b, e0i, e1i;
    logic         sen;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R6 reset values
        check("R6 oe two-way", W'(b_oe), '0);
        check("R6 oe transmit", W'(o_oe), W'(1));
        check("R6 rx lane0", b_r0, '0);
        check("R6 rx lane1", b_r1, '0);
        check("R6 pad shows mask", b_po, MASK_B);
        check("R8 rx-only oe", W'(i_oe), '0);
        @(negedge clk);
        #1 rst = 1'b0;

        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            #1;
            e0b = rise_b; e1b = fall_b;
            e0i = rise_i; e1i = fall_i;
            rise_b = pad_in ^ MASK_B;
            rise_i = pad_in ^ MASK_I;
            check("R1 lane0 two-way", b_r0, e0b);
            check("R2 lane1 two-way", b_r1, e1b);
            check("R1 lane0 rx-only", i_r0, e0i);
            check("R2 lane1 rx-only", i_r1, e1i);
            check("R8 tx-only lane0", o_r0, '0);
            check("R8 tx-only lane1", o_r1, '0);
            s0 = tx0; s1 = tx1; sen = tx_en;
            check("R4 high phase two-way", b_po, s0 ^ MASK_B);
            check("R4 high phase tx-only", o_po, s0);
            check("R5 oe high two-way", W'(b_oe), W'(sen));
            check("R5 oe high tx-only", W'(o_oe), W'(sen));
            check("R7 diff leg high", b_pn, ~b_po);
            check("R7 single leg", o_pn, '0);
            check("R8 rx-only pad_out", i_po, '0);
            check("R8 rx-only oe", W'(i_oe), '0);
            h0 = b_r0; h1 = b_r1;
            pad_in = pattern(2 * k);
            tx0    = pattern(2 * k + 7);
            tx1    = ~pattern(2 * k + 3);
            tx_en  = (k < 64) ? (k % 3 != 0) : 1'($urandom);

            @(negedge clk);
            #1;
            fall_b = pad_in ^ MASK_B;
            fall_i = pad_in ^ MASK_I;
            check("R3 lane0 holds", b_r0, h0);
            check("R3 lane1 holds", b_r1, h1);
            check("R4 low phase two-way", b_po, s1 ^ MASK_B);
            check("R4 low phase tx-only", o_po, s1);
            check("R5 oe low two-way", W'(b_oe), W'(sen));
            check("R7 diff leg low", b_pn, ~b_po);
            pad_in = pattern(2 * k + 1);
        end
        finish_run();
    end
endmodule